// File: doc/BRIEF.md
# PCI Target Address Window Translator

This block sits behind the address phase of a PCI target. It decides whether an incoming address belongs to this device and rewrites it into an address on the local bus. Two memory windows are provided. Each one has a PCI-side base, a local-side base and a size mask. A separate 256-byte I/O window reaches the device's internal registers. Memory commands are decoded only against the memory windows, and I/O commands only against the I/O window.

The size mask picks which address bits form the offset. Offset bits pass through unchanged. The remaining bits must equal the PCI base, and on a hit they are replaced by the local base. The block never checks whether memory is installed behind a window, so any address inside a programmed window is claimed. I/O accesses ignore the byte enables and are always treated as full 32-bit words. A burst I/O request is claimed but flagged as unsupported.

The decode result is registered and appears one clock after the address is presented. Window registers are loaded through a simple write port.

Top module: `pci_win_xlate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, hit, unsup, win_idx, local_addr and be_out are all zero. Reset clears every base to zero and sets each size mask to its minimum value of 0x000F_FFFF.
- R2: A write with cfg_we=1 loads cfg_wdata into the register chosen by cfg_sel. The select codes are: 0 = window 0 PCI base, 1 = window 0 local base, 2 = window 0 size mask, 3 = window 1 PCI base, 4 = window 1 local base, 5 = window 1 size mask, 6 = I/O base. Code 7 writes nothing.
- R3: Bits [19:0] of a size mask always read as set, whatever value is written. Each set bit marks an offset bit, so a memory window is never smaller than 1 MB.
- R4: A memory command (cmd = 0 for read, 1 for write) hits window w when addr equals that window's PCI base on every bit where the mask is clear. On a hit, local_addr = (local base AND NOT mask) OR (addr AND mask), and be_out = byte_en.
- R5: When no window matches, or addr_valid is low, the next cycle shows hit=0, unsup=0, win_idx=0, local_addr=0 and be_out=0.
- R6: When both memory windows match, window 0 wins and win_idx=0.
- R7: Every address inside a window is claimed, including the top offset of a large window.
- R8: An I/O command (cmd = 2 for read, 3 for write) hits when addr[31:8] equals the I/O base bits [31:8]. On a hit, win_idx=2 and local_addr = {24'b0, addr[7:2], 2'b00}. The I/O base bits [7:0] are ignored.
- R9: On an I/O hit, be_out=4'hF whatever byte_en holds.
- R10: An I/O hit with burst=1 gives hit=1 and unsup=1. An I/O hit with burst=0 gives unsup=0, and a memory hit never sets unsup.
- R11: Memory commands never hit the I/O window, and I/O commands never hit a memory window.
- R12: The outputs reflect the access sampled on the previous clock edge. A register write affects accesses sampled on later edges, but not an access sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Address phase present this cycle |
| addr | input | 32 | Incoming PCI address |
| cmd | input | 2 | 0 mem read, 1 mem write, 2 I/O read, 3 I/O write |
| byte_en | input | 4 | Byte enables, active high |
| burst | input | 1 | Access is a burst |
| hit | output | 1 | Access claimed |
| win_idx | output | 2 | 0/1 memory window, 2 I/O window |
| local_addr | output | 32 | Translated local address |
| unsup | output | 1 | Claimed transfer is not supported |
| be_out | output | 4 | Byte enables to apply locally |

## Verification
The bench builds the block with its default parameters: two memory windows, a 1 MB minimum window and a 256-byte I/O window. These values make the window-0 priority, the forced low mask bits and the I/O offset slice reachable with directed addresses. Masks of unequal width bring both the splice position and window overlap within reach. A random phase then aims addresses at the base of each window and mixes command classes, burst flags and byte-enable patterns.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'd0,
    CMD_MEM_WR = 2'd1,
    CMD_IO_RD  = 2'd2,
    CMD_IO_WR  = 2'd3
  } pci_cmd_e;

  // register kinds inside one memory window slot
  localparam int unsigned KIND_PCI_BASE  = 0;
  localparam int unsigned KIND_LOC_BASE  = 1;
  localparam int unsigned KIND_SIZE_MASK = 2;
  localparam int unsigned REGS_PER_WIN   = 3;

  function automatic logic cmd_is_io(input logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/pci_xlate_regs.sv
module pci_xlate_regs
  import pci_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned NUM_MEM_WIN  = 2,
  parameter int unsigned MIN_WIN_LOG2 = 20,
  parameter int unsigned IO_LOG2      = 8,
  parameter int unsigned SEL_W        = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [SEL_W-1:0]                    cfg_sel,
  input  logic [ADDR_W-1:0]                   cfg_wdata,
  output logic [NUM_MEM_WIN-1:0][ADDR_W-1:0]  pci_base,
  output logic [NUM_MEM_WIN-1:0][ADDR_W-1:0]  loc_base,
  output logic [NUM_MEM_WIN-1:0][ADDR_W-1:0]  size_mask,
  output logic [ADDR_W-1:0]                   io_base
);
  localparam logic [ADDR_W-1:0] MIN_MASK = ADDR_W'((64'd1 << MIN_WIN_LOG2) - 64'd1);
  localparam logic [ADDR_W-1:0] IO_LO    = ADDR_W'((64'd1 << IO_LOG2) - 64'd1);
  localparam int unsigned       IO_SEL   = REGS_PER_WIN * NUM_MEM_WIN;

  logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] pci_q, pci_n, loc_q, loc_n, msk_q, msk_n;
  logic [ADDR_W-1:0]                  io_q, io_n;

  always_comb begin
    pci_n = pci_q;
    loc_n = loc_q;
    msk_n = msk_q;
    io_n  = io_q;
    for (int w = 0; w < NUM_MEM_WIN; w++) begin
      if (cfg_sel == SEL_W'(REGS_PER_WIN * w + KIND_PCI_BASE))  pci_n[w] = cfg_wdata;
      if (cfg_sel == SEL_W'(REGS_PER_WIN * w + KIND_LOC_BASE))  loc_n[w] = cfg_wdata;
      if (cfg_sel == SEL_W'(REGS_PER_WIN * w + KIND_SIZE_MASK)) msk_n[w] = cfg_wdata | MIN_MASK;
    end
    if (cfg_sel == SEL_W'(IO_SEL)) io_n = cfg_wdata & ~IO_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_q <= '0;
      loc_q <= '0;
      msk_q <= {NUM_MEM_WIN{MIN_MASK}};
      io_q  <= '0;
    end else if (cfg_we) begin
      pci_q <= pci_n;
      loc_q <= loc_n;
      msk_q <= msk_n;
      io_q  <= io_n;
    end
  end

  assign pci_base  = pci_q;
  assign loc_base  = loc_q;
  assign size_mask = msk_q;
  assign io_base   = io_q;
endmodule

// File: rtl/pci_mem_win.sv
module pci_mem_win #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pci_base,
  input  logic [ADDR_W-1:0] loc_base,
  input  logic [ADDR_W-1:0] size_mask,
  output logic              match,
  output logic [ADDR_W-1:0] xlat
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff  = (addr ^ pci_base) & ~size_mask;
    match = (diff == '0);
    xlat  = (loc_base & ~size_mask) | (addr & size_mask);
  end
endmodule

// File: rtl/pci_io_win.sv
module pci_io_win #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IO_LOG2 = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] io_base,
  input  logic              burst,
  output logic              match,
  output logic              unsup,
  output logic [ADDR_W-1:0] xlat
);
  logic unused_lo;
  assign unused_lo = ^{addr[1:0], io_base[IO_LOG2-1:0]};

  always_comb begin
    match               = (addr[ADDR_W-1:IO_LOG2] == io_base[ADDR_W-1:IO_LOG2]);
    unsup               = match & burst;
    xlat                = '0;
    xlat[IO_LOG2-1:2]   = addr[IO_LOG2-1:2];
  end
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
  import pci_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned NUM_MEM_WIN  = 2,
  parameter int unsigned MIN_WIN_LOG2 = 20,
  parameter int unsigned IO_LOG2      = 8,
  parameter int unsigned BE_W         = 4,
  parameter int unsigned SEL_W        = $clog2(REGS_PER_WIN * NUM_MEM_WIN + 1),
  parameter int unsigned IDX_W        = $clog2(NUM_MEM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmd,
  input  logic [BE_W-1:0]   byte_en,
  input  logic              burst,
  output logic              hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic [ADDR_W-1:0] local_addr,
  output logic              unsup,
  output logic [BE_W-1:0]   be_out
);
  localparam logic [IDX_W-1:0] IO_IDX = IDX_W'(NUM_MEM_WIN);

  logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] pci_base, loc_base, size_mask, mem_xlat;
  logic [NUM_MEM_WIN-1:0]             mem_match;
  logic [ADDR_W-1:0]                  io_base, io_xlat;
  logic                               io_match, io_unsup;

  pci_xlate_regs #(
    .ADDR_W(ADDR_W), .NUM_MEM_WIN(NUM_MEM_WIN), .MIN_WIN_LOG2(MIN_WIN_LOG2),
    .IO_LOG2(IO_LOG2), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pci_base(pci_base), .loc_base(loc_base), .size_mask(size_mask), .io_base(io_base)
  );

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
    pci_mem_win #(.ADDR_W(ADDR_W)) u_win (
      .addr(addr), .pci_base(pci_base[w]), .loc_base(loc_base[w]),
      .size_mask(size_mask[w]), .match(mem_match[w]), .xlat(mem_xlat[w])
    );
  end

  pci_io_win #(.ADDR_W(ADDR_W), .IO_LOG2(IO_LOG2)) u_io (
    .addr(addr), .io_base(io_base), .burst(burst),
    .match(io_match), .unsup(io_unsup), .xlat(io_xlat)
  );

  // priority select: lowest window index wins
  logic              mem_any;
  logic [IDX_W-1:0]  mem_idx;
  logic [ADDR_W-1:0] mem_sel_addr;

  always_comb begin
    mem_any      = 1'b0;
    mem_idx      = '0;
    mem_sel_addr = '0;
    for (int w = NUM_MEM_WIN - 1; w >= 0; w--) begin
      if (mem_match[w]) begin
        mem_any      = 1'b1;
        mem_idx      = IDX_W'(w);
        mem_sel_addr = mem_xlat[w];
      end
    end
  end

  logic              hit_n, unsup_n;
  logic [IDX_W-1:0]  idx_n;
  logic [ADDR_W-1:0] loc_n;
  logic [BE_W-1:0]   be_n;

  always_comb begin
    hit_n   = 1'b0;
    unsup_n = 1'b0;
    idx_n   = '0;
    loc_n   = '0;
    be_n    = '0;
    if (addr_valid) begin
      if (cmd_is_io(cmd)) begin
        if (io_match) begin
          hit_n   = 1'b1;
          unsup_n = io_unsup;
          idx_n   = IO_IDX;
          loc_n   = io_xlat;
          be_n    = '1;
        end
      end else if (mem_any) begin
        hit_n = 1'b1;
        idx_n = mem_idx;
        loc_n = mem_sel_addr;
        be_n  = byte_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= 1'b0;
      unsup      <= 1'b0;
      win_idx    <= '0;
      local_addr <= '0;
      be_out     <= '0;
    end else begin
      hit        <= hit_n;
      unsup      <= unsup_n;
      win_idx    <= idx_n;
      local_addr <= loc_n;
      be_out     <= be_n;
    end
  end
endmodule

// File: rtl/pci_win_xlate_chk.sv
module pci_win_xlate_chk #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned NUM_MEM_WIN  = 2,
  parameter int unsigned MIN_WIN_LOG2 = 20,
  parameter int unsigned BE_W         = 4,
  parameter int unsigned IDX_W        = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        cmd,
  input logic              burst,
  input logic              hit,
  input logic [IDX_W-1:0]  win_idx,
  input logic [ADDR_W-1:0] local_addr,
  input logic              unsup,
  input logic [BE_W-1:0]   be_out
);
  localparam logic [IDX_W-1:0] IO_IDX = IDX_W'(NUM_MEM_WIN);

  logic unused_chk;
  assign unused_chk = ^{addr[ADDR_W-1:MIN_WIN_LOG2], cmd[0]};

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(addr_valid)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!unsup && local_addr == '0 && be_out == '0)); // R5
  AST_UNSUP_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> (hit && win_idx == IO_IDX)); // R10
  AST_IO_BURST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx == IO_IDX) |-> (unsup == $past(burst))); // R10
  AST_IO_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx == IO_IDX) |-> (be_out == '1 && local_addr[1:0] == 2'b00)); // R9
  AST_CMD_CLASS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx == IO_IDX) |-> $past(cmd[1])); // R11
  AST_CMD_CLASS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx < IO_IDX) |-> !$past(cmd[1])); // R11
  AST_MEM_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx < IO_IDX) |->
      (local_addr[MIN_WIN_LOG2-1:0] == $past(addr[MIN_WIN_LOG2-1:0]))); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_idx <= IO_IDX); // R8
endmodule

bind pci_win_xlate pci_win_xlate_chk #(
  .ADDR_W(ADDR_W), .NUM_MEM_WIN(NUM_MEM_WIN), .MIN_WIN_LOG2(MIN_WIN_LOG2),
  .BE_W(BE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr), .cmd(cmd),
  .burst(burst), .hit(hit), .win_idx(win_idx), .local_addr(local_addr),
  .unsup(unsup), .be_out(be_out)
);

// File: tb/pci_win_xlate_bench.sv
`timescale 1ns/1ps
module pci_win_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_valid = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  cmd = '0;
  logic [3:0]  byte_en = '0;
  logic        burst = 1'b0;
  logic        hit, unsup;
  logic [1:0]  win_idx;
  logic [31:0] local_addr;
  logic [3:0]  be_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pci_win_xlate u_pci_win_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_valid(addr_valid), .addr(addr), .cmd(cmd), .byte_en(byte_en), .burst(burst),
    .hit(hit), .win_idx(win_idx), .local_addr(local_addr), .unsup(unsup), .be_out(be_out)
  );

  // behavioural reference model
  logic [31:0] m_pci [2];
  logic [31:0] m_loc [2];
  logic [31:0] m_msk [2];
  logic [31:0] m_io;
  logic        e_hit, e_uns;
  logic [1:0]  e_idx;
  logic [31:0] e_loc;
  logic [3:0]  e_be;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        m_pci[w] = 0; m_loc[w] = 0; m_msk[w] = 32'h000F_FFFF;
      end
      m_io = 0;
      e_hit = 0; e_uns = 0; e_idx = 0; e_loc = 0; e_be = 0;
    end else begin
      e_hit = 0; e_uns = 0; e_idx = 0; e_loc = 0; e_be = 0;
      if (addr_valid) begin
        if (cmd >= 2) begin
          if ((addr >> 8) == (m_io >> 8)) begin
            e_hit = 1; e_idx = 2; e_uns = burst; e_be = 4'hF;
            e_loc = addr % 256;
            e_loc = e_loc - (e_loc % 4);
          end
        end else begin
          for (int w = 1; w >= 0; w--) begin
            if (((addr ^ m_pci[w]) & ~m_msk[w]) == 0) begin
              e_hit = 1; e_idx = 2'(w); e_be = byte_en;
              e_loc = (m_loc[w] & ~m_msk[w]) | (addr & m_msk[w]);
            end
          end
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_pci[0] = cfg_wdata;
          3'd1: m_loc[0] = cfg_wdata;
          3'd2: m_msk[0] = cfg_wdata | 32'h000F_FFFF;
          3'd3: m_pci[1] = cfg_wdata;
          3'd4: m_loc[1] = cfg_wdata;
          3'd5: m_msk[1] = cfg_wdata | 32'h000F_FFFF;
          3'd6: m_io     = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic compare(input string tag);
    vectors++;
    if (hit !== e_hit || unsup !== e_uns || win_idx !== e_idx ||
        local_addr !== e_loc || be_out !== e_be) begin
      errors++;
      $display("FAIL %s: actual hit=%0b idx=%0d loc=%h uns=%0b be=%h expected hit=%0b idx=%0d loc=%h uns=%0b be=%h",
               tag, hit, win_idx, local_addr, unsup, be_out, e_hit, e_idx, e_loc, e_uns, e_be);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_in();
    cfg_we = 0; addr_valid = 0; burst = 0; byte_en = 0; cmd = 0; addr = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
    idle_in();
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    cyc(tag);
    cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] c, input logic [3:0] be,
                     input logic b, input string tag);
    idle_in();
    addr_valid = 1; addr = a; cmd = c; byte_en = be; burst = b;
    cyc(tag);
    idle_in();
    cyc(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    cyc("R1 after release");
    acc(32'h0000_0040, 2'd0, 4'h3, 0, "R1 reset window0 at zero");

    wr(3'd0, 32'h4000_0000, "R2 win0 pci");
    wr(3'd1, 32'h0C00_0000, "R2 win0 loc");
    wr(3'd2, 32'h0000_0000, "R3 win0 mask min");
    wr(3'd3, 32'h8000_0000, "R2 win1 pci");
    wr(3'd4, 32'h1000_0000, "R2 win1 loc");
    wr(3'd5, 32'h00FF_0000, "R3 win1 mask low forced");
    wr(3'd6, 32'h0000_12AB, "R8 io base low ignored");
    wr(3'd7, 32'hFFFF_FFFF, "R2 code7 no effect");

    acc(32'h4001_2344, 2'd0, 4'h3, 0, "R4 win0 read");
    acc(32'h80AB_CDEF, 2'd1, 4'hC, 1, "R4 win1 write burst");
    acc(32'h80FF_FFFF, 2'd0, 4'hF, 0, "R7 win1 top offset");
    acc(32'h4010_0000, 2'd0, 4'hF, 0, "R5 just past win0");
    acc(32'h0000_0000, 2'd0, 4'hF, 0, "R5 miss low");
    acc(32'h0000_1234, 2'd2, 4'h0, 0, "R8 io read");
    acc(32'h0000_12FF, 2'd3, 4'h5, 0, "R9 io byte enables");
    acc(32'h0000_1208, 2'd3, 4'h1, 1, "R10 io burst");
    acc(32'h0000_1300, 2'd2, 4'h0, 0, "R8 io miss");
    acc(32'h4000_0010, 2'd2, 4'h0, 0, "R11 io cmd on mem window");
    acc(32'h0000_1234, 2'd0, 4'hF, 0, "R11 mem cmd on io window");

    idle_in();
    addr = 32'h4000_0000; cmd = 0; byte_en = 4'hF;
    cyc("R5 valid low");

    wr(3'd3, 32'h4000_0000, "R6 win1 overlap");
    wr(3'd5, 32'h0FFF_FFFF, "R6 win1 wide mask");
    acc(32'h4008_0000, 2'd0, 4'hF, 0, "R6 both match");
    acc(32'h4F00_0004, 2'd1, 4'h2, 0, "R6 only win1");

    // same-edge write and access
    idle_in();
    cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = 32'h2000_0000;
    addr_valid = 1; addr = 32'h4000_0100; cmd = 0; byte_en = 4'hF;
    cyc("R12 access with write same edge");
    idle_in();
    addr_valid = 1; addr = 32'h2000_0100; cmd = 0; byte_en = 4'h1;
    cyc("R12 access after write");
    idle_in();
    cyc("R12 drain");

    for (int i = 0; i < 400; i++) begin
      idle_in();
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; cfg_sel = 3'($urandom_range(0, 7)); cfg_wdata = $urandom;
      end
      addr_valid = ($urandom_range(0, 4) != 0);
      cmd = 2'($urandom_range(0, 3));
      byte_en = 4'($urandom);
      burst = 1'($urandom);
      case ($urandom_range(0, 3))
        0: addr = m_pci[0] ^ ($urandom & 32'h001F_FFFF);
        1: addr = m_pci[1] ^ ($urandom & 32'h00FF_FFFF);
        2: addr = m_io ^ ($urandom & 32'h0000_01FF);
        default: addr = $urandom;
      endcase
      cyc("R4 R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule